// File: doc/BRIEF.md
# Per-Account Credit Exposure Gate

This block keeps a running credit exposure figure and a credit ceiling for every client account, and decides for each incoming order whether it fits under that account's ceiling. An order arrives as an account index, a quantity and a price. The block multiplies quantity by price to get the order's notional value. It adds that value to the account's current exposure and compares the sum with the ceiling. Two cycles after the order is presented it reports a pass or fail flag for that order.

Exposure is only consumed once the order is finally accepted. Other checks elsewhere in the order path drive a final accept input in the cycle the decision is shown. Only a passing decision with accept high adds the notional to the account. The following cycle the block reports which account was charged and its new exposure. A second order for the same account, one cycle behind, already includes the notional of the order being charged in that cycle. Its check therefore never works from a stale exposure value.

A host port sets ceilings, overwrites or clears exposures, and a separate release port lowers an account's exposure, for example when an order is cancelled.

Top module: `credit_exposure_checker`

## Requirements
- R1: After reset no decision and no charge is reported. Every exposure and every ceiling is zero, so an order of zero notional passes and one of notional 1 fails.
- R2: An order presented with ord_valid in cycle c shows chk_valid in cycle c+2, with chk_acct equal to its account. Its notional is ord_qty times ord_price.
- R3: An order passes when exposure plus notional is at most the ceiling. A sum exactly equal to the ceiling passes; a sum one above fails.
- R4: An account is charged only in a cycle where chk_valid, chk_pass and fin_accept are all high. The next cycle shows cmt_valid, cmt_acct and cmt_total, the account's new exposure. A failed or unaccepted order leaves the exposure unchanged.
- R5: When an order is charged in the cycle its follower for the same account is being checked, the follower's check includes that charge. An unaccepted predecessor is not counted.
- R6: host_op code 0 writes host_data as the ceiling of host_acct. It applies to orders presented in the same cycle as the write or later.
- R7: host_op code 1 writes host_data as the exposure of host_acct, and code 2 sets it to zero. Code 3 changes nothing. Like R6, these apply to orders presented in the same cycle or later.
- R8: A release lowers the account's exposure by rel_amount and stops at zero.
- R9: When a host exposure write, a release and a charge hit one account in one cycle, they apply in that order: host write first, then release, then charge.
- R10: A charge that would carry the exposure past the largest value the exposure field can hold leaves it at that largest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ord_valid | input | 1 | Order present this cycle |
| ord_acct | input | AW | Order account index |
| ord_qty | input | QW | Order quantity |
| ord_price | input | PW | Order price |
| fin_accept | input | 1 | Final accept for the decision shown this cycle |
| host_valid | input | 1 | Host operation present |
| host_op | input | 2 | 0 ceiling write, 1 exposure write, 2 exposure clear, 3 no effect |
| host_acct | input | AW | Host target account |
| host_data | input | EW | Ceiling or exposure value |
| rel_valid | input | 1 | Release present |
| rel_acct | input | AW | Release account |
| rel_amount | input | EW | Amount to subtract |
| chk_valid | output | 1 | Decision valid |
| chk_pass | output | 1 | Decision is pass |
| chk_acct | output | AW | Account of the decision |
| cmt_valid | output | 1 | An account was charged last cycle |
| cmt_acct | output | AW | Charged account |
| cmt_total | output | EW | Exposure of that account after the charge |

## Verification
The assertions take for granted that ord_valid stays low while reset is applied and during the two-cycle internal release window. They also assume account indices always lie below the account count. A fin_accept outside a passing decision is allowed and must be ignored. The bench holds orders off for several cycles after reset and draws accounts only from the valid range, mostly from four accounts so that back-to-back same-account orders are frequent. It drives fin_accept at random in every cycle, so idle and failing cycles also see accept pulses.

// File: rtl/cec_pkg.sv
package cec_pkg;
  typedef enum logic [1:0] {
    HOP_LIMIT = 2'd0,
    HOP_EXPO  = 2'd1,
    HOP_CLEAR = 2'd2,
    HOP_NOP   = 2'd3
  } host_op_e;
endpackage

// File: rtl/cec_rst_sync.sv
module cec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cec_order_stage.sv
module cec_order_stage #(
  parameter int AW = 4,
  parameter int QW = 16,
  parameter int PW = 16,
  parameter int NW = QW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_acct,
  input  logic [QW-1:0] in_qty,
  input  logic [PW-1:0] in_price,
  output logic          s1_valid,
  output logic [AW-1:0] s1_acct,
  output logic [NW-1:0] s1_notional
);
  logic [NW-1:0] notional_d;

  // notional of the incoming order, full product width
  always_comb begin
    notional_d = {{PW{1'b0}}, in_qty} * {{QW{1'b0}}, in_price};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_acct     <= '0;
      s1_notional <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_acct     <= in_acct;
        s1_notional <= notional_d;
      end
    end
  end
endmodule

// File: rtl/cec_limit_bank.sv
module cec_limit_bank
  import cec_pkg::*;
#(
  parameter int NACCT = 16,
  parameter int AW    = 4,
  parameter int EW    = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  input  host_op_e      host_op,
  input  logic [AW-1:0] host_acct,
  input  logic [EW-1:0] host_data,
  input  logic [AW-1:0] rd_acct,
  output logic [EW-1:0] rd_lim
);
  logic [EW-1:0] lim_q [NACCT];

  for (genvar gi = 0; gi < NACCT; gi++) begin : g_lim
    logic wr_en;

    always_comb begin
      wr_en = host_valid && (host_op == HOP_LIMIT) && (host_acct == AW'(gi));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lim_q[gi] <= '0;
      else if (wr_en) lim_q[gi] <= host_data;
    end
  end

  assign rd_lim = lim_q[rd_acct];
endmodule

// File: rtl/cec_exposure_bank.sv
module cec_exposure_bank
  import cec_pkg::*;
#(
  parameter int NACCT = 16,
  parameter int AW    = 4,
  parameter int NW    = 32,
  parameter int EW    = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_acct,
  output logic [EW-1:0] rd_exp,
  input  logic          host_valid,
  input  host_op_e      host_op,
  input  logic [AW-1:0] host_acct,
  input  logic [EW-1:0] host_data,
  input  logic          rel_valid,
  input  logic [AW-1:0] rel_acct,
  input  logic [EW-1:0] rel_amount,
  input  logic          cmt_en,
  input  logic [AW-1:0] cmt_acct_i,
  input  logic [NW-1:0] cmt_amt,
  output logic          cmt_valid,
  output logic [AW-1:0] cmt_acct,
  output logic [EW-1:0] cmt_total
);
  logic [EW-1:0] exp_q [NACCT];
  logic [EW-1:0] cmt_total_d;

  // host write, then release (floored at zero), then charge (capped at all ones)
  function automatic logic [EW-1:0] next_exposure(
    input logic [EW-1:0] cur,
    input logic          h_hit,
    input host_op_e      op,
    input logic [EW-1:0] hdata,
    input logic          r_hit,
    input logic [EW-1:0] ramt,
    input logic          c_hit,
    input logic [NW-1:0] camt
  );
    logic [EW-1:0] v;
    logic [EW:0]   s;
    v = cur;
    if (h_hit && op == HOP_EXPO)       v = hdata;
    else if (h_hit && op == HOP_CLEAR) v = '0;
    if (r_hit) v = (v > ramt) ? (v - ramt) : '0;
    s = {1'b0, v} + {{(EW + 1 - NW){1'b0}}, camt};
    if (c_hit) v = s[EW] ? '1 : s[EW-1:0];
    return v;
  endfunction

  for (genvar gi = 0; gi < NACCT; gi++) begin : g_exp
    logic          h_hit;
    logic          r_hit;
    logic          c_hit;
    logic          upd_en;
    logic [EW-1:0] exp_d;

    always_comb begin
      h_hit  = host_valid && (host_acct == AW'(gi));
      r_hit  = rel_valid && (rel_acct == AW'(gi));
      c_hit  = cmt_en && (cmt_acct_i == AW'(gi));
      upd_en = (h_hit && (host_op == HOP_EXPO || host_op == HOP_CLEAR)) || r_hit || c_hit;
      exp_d  = next_exposure(exp_q[gi], h_hit, host_op, host_data,
                             r_hit, rel_amount, c_hit, cmt_amt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      exp_q[gi] <= '0;
      else if (upd_en) exp_q[gi] <= exp_d;
    end
  end

  always_comb begin
    cmt_total_d = next_exposure(exp_q[cmt_acct_i],
                                host_valid && (host_acct == cmt_acct_i), host_op, host_data,
                                rel_valid && (rel_acct == cmt_acct_i), rel_amount,
                                1'b1, cmt_amt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmt_valid <= 1'b0;
      cmt_acct  <= '0;
      cmt_total <= '0;
    end else begin
      cmt_valid <= cmt_en;
      if (cmt_en) begin
        cmt_acct  <= cmt_acct_i;
        cmt_total <= cmt_total_d;
      end
    end
  end

  assign rd_exp = exp_q[rd_acct];
endmodule

// File: rtl/cec_decide.sv
module cec_decide #(
  parameter int AW = 4,
  parameter int NW = 32,
  parameter int EW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_valid,
  input  logic [AW-1:0] s1_acct,
  input  logic [NW-1:0] s1_notional,
  input  logic [EW-1:0] cur_exp,
  input  logic [EW-1:0] cur_lim,
  input  logic          fin_accept,
  output logic          chk_valid,
  output logic          chk_pass,
  output logic [AW-1:0] chk_acct,
  output logic          cmt_en,
  output logic [AW-1:0] cmt_acct,
  output logic [NW-1:0] cmt_amt
);
  localparam int TW = EW + 2;

  logic [NW-1:0] dec_notional_q;
  logic [NW-1:0] fwd_amt;
  logic [TW-1:0] total;
  logic          fits;

  always_comb begin
    cmt_en   = chk_valid && chk_pass && fin_accept;
    cmt_acct = chk_acct;
    cmt_amt  = dec_notional_q;
    // charge landing at this edge is not yet in the bank: forward it
    fwd_amt  = (cmt_en && (chk_acct == s1_acct)) ? dec_notional_q : '0;
    total    = TW'(cur_exp) + TW'(fwd_amt) + TW'(s1_notional);
    fits     = (total <= TW'(cur_lim));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid      <= 1'b0;
      chk_pass       <= 1'b0;
      chk_acct       <= '0;
      dec_notional_q <= '0;
    end else begin
      chk_valid <= s1_valid;
      if (s1_valid) begin
        chk_pass       <= fits;
        chk_acct       <= s1_acct;
        dec_notional_q <= s1_notional;
      end
    end
  end
endmodule

// File: rtl/credit_exposure_checker.sv
module credit_exposure_checker
  import cec_pkg::*;
#(
  parameter int  NACCT = 16,
  parameter int  QW    = 16,
  parameter int  PW    = 16,
  parameter int  EW    = 40,
  localparam int AW    = (NACCT > 1) ? $clog2(NACCT) : 1,
  localparam int NW    = QW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ord_valid,
  input  logic [AW-1:0] ord_acct,
  input  logic [QW-1:0] ord_qty,
  input  logic [PW-1:0] ord_price,
  input  logic          fin_accept,
  input  logic          host_valid,
  input  logic [1:0]    host_op,
  input  logic [AW-1:0] host_acct,
  input  logic [EW-1:0] host_data,
  input  logic          rel_valid,
  input  logic [AW-1:0] rel_acct,
  input  logic [EW-1:0] rel_amount,
  output logic          chk_valid,
  output logic          chk_pass,
  output logic [AW-1:0] chk_acct,
  output logic          cmt_valid,
  output logic [AW-1:0] cmt_acct,
  output logic [EW-1:0] cmt_total
);
  logic          rst_i_n;
  host_op_e      hop;
  logic          s1_valid;
  logic [AW-1:0] s1_acct;
  logic [NW-1:0] s1_notional;
  logic [EW-1:0] cur_exp;
  logic [EW-1:0] cur_lim;
  logic          cmt_en;
  logic [AW-1:0] cmt_acct_w;
  logic [NW-1:0] cmt_amt;

  assign hop = host_op_e'(host_op);

  cec_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cec_order_stage #(.AW(AW), .QW(QW), .PW(PW), .NW(NW)) u_ord (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .in_valid    (ord_valid),
    .in_acct     (ord_acct),
    .in_qty      (ord_qty),
    .in_price    (ord_price),
    .s1_valid    (s1_valid),
    .s1_acct     (s1_acct),
    .s1_notional (s1_notional)
  );

  cec_limit_bank #(.NACCT(NACCT), .AW(AW), .EW(EW)) u_lim (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .host_valid (host_valid),
    .host_op    (hop),
    .host_acct  (host_acct),
    .host_data  (host_data),
    .rd_acct    (s1_acct),
    .rd_lim     (cur_lim)
  );

  cec_exposure_bank #(.NACCT(NACCT), .AW(AW), .NW(NW), .EW(EW)) u_exp (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .rd_acct    (s1_acct),
    .rd_exp     (cur_exp),
    .host_valid (host_valid),
    .host_op    (hop),
    .host_acct  (host_acct),
    .host_data  (host_data),
    .rel_valid  (rel_valid),
    .rel_acct   (rel_acct),
    .rel_amount (rel_amount),
    .cmt_en     (cmt_en),
    .cmt_acct_i (cmt_acct_w),
    .cmt_amt    (cmt_amt),
    .cmt_valid  (cmt_valid),
    .cmt_acct   (cmt_acct),
    .cmt_total  (cmt_total)
  );

  cec_decide #(.AW(AW), .NW(NW), .EW(EW)) u_dec (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .s1_valid    (s1_valid),
    .s1_acct     (s1_acct),
    .s1_notional (s1_notional),
    .cur_exp     (cur_exp),
    .cur_lim     (cur_lim),
    .fin_accept  (fin_accept),
    .chk_valid   (chk_valid),
    .chk_pass    (chk_pass),
    .chk_acct    (chk_acct),
    .cmt_en      (cmt_en),
    .cmt_acct    (cmt_acct_w),
    .cmt_amt     (cmt_amt)
  );
endmodule

// File: rtl/cec_checker.sv
module cec_checker #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ord_valid,
  input logic [AW-1:0] ord_acct,
  input logic          fin_accept,
  input logic          chk_valid,
  input logic          chk_pass,
  input logic [AW-1:0] chk_acct,
  input logic          cmt_valid,
  input logic [AW-1:0] cmt_acct
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!chk_valid && !cmt_valid); // R1
    end
  end

  AST_DECISION_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $past(ord_valid, 2)); // R2

  AST_DECISION_ACCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> (chk_acct == $past(ord_acct, 2))); // R2

  AST_CHARGE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> $past(chk_valid && chk_pass && fin_accept)); // R4

  AST_CHARGE_ACCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> (cmt_acct == $past(chk_acct))); // R4

  AST_FAIL_NO_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_pass) |=> !cmt_valid); // R4
endmodule

bind credit_exposure_checker cec_checker #(.AW(AW)) u_cec_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ord_valid  (ord_valid),
  .ord_acct   (ord_acct),
  .fin_accept (fin_accept),
  .chk_valid  (chk_valid),
  .chk_pass   (chk_pass),
  .chk_acct   (chk_acct),
  .cmt_valid  (cmt_valid),
  .cmt_acct   (cmt_acct)
);

// File: tb/credit_exposure_checker_tb_top.sv
module credit_exposure_checker_tb_top;
  localparam int NACCT = 16;
  localparam int QW    = 16;
  localparam int PW    = 16;
  localparam int EW    = 40;
  localparam int AW    = 4;
  localparam longint unsigned EMAX = (64'd1 << EW) - 64'd1;

  logic          clk;
  logic          rst_n;
  logic          ord_valid;
  logic [AW-1:0] ord_acct;
  logic [QW-1:0] ord_qty;
  logic [PW-1:0] ord_price;
  logic          fin_accept;
  logic          host_valid;
  logic [1:0]    host_op;
  logic [AW-1:0] host_acct;
  logic [EW-1:0] host_data;
  logic          rel_valid;
  logic [AW-1:0] rel_acct;
  logic [EW-1:0] rel_amount;
  logic          chk_valid;
  logic          chk_pass;
  logic [AW-1:0] chk_acct;
  logic          cmt_valid;
  logic [AW-1:0] cmt_acct;
  logic [EW-1:0] cmt_total;

  credit_exposure_checker #(.NACCT(NACCT), .QW(QW), .PW(PW), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ord_valid(ord_valid), .ord_acct(ord_acct),
    .ord_qty(ord_qty), .ord_price(ord_price), .fin_accept(fin_accept),
    .host_valid(host_valid), .host_op(host_op), .host_acct(host_acct),
    .host_data(host_data), .rel_valid(rel_valid), .rel_acct(rel_acct),
    .rel_amount(rel_amount), .chk_valid(chk_valid), .chk_pass(chk_pass),
    .chk_acct(chk_acct), .cmt_valid(cmt_valid), .cmt_acct(cmt_acct),
    .cmt_total(cmt_total)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference state derived from the requirements
  longint unsigned m_exp [NACCT];
  longint unsigned m_lim [NACCT];
  bit              s1v, dv, dp;
  int              s1a, da;
  longint unsigned s1n, dn;

  task automatic check(string tag, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit ov, int oa, int oq, int op_,
                      bit hv, int hop, int ha, longint unsigned hd,
                      bit rv, int ra, longint unsigned rd, bit fa);
    bit              cm, np, e_chkv, e_chkp, e_cmtv;
    int              e_chka, e_cmta;
    longint unsigned fwd, v, e_cmtt;
    ord_valid  = ov;  ord_acct  = oa[AW-1:0]; ord_qty = oq[QW-1:0]; ord_price = op_[PW-1:0];
    host_valid = hv;  host_op   = hop[1:0];   host_acct = ha[AW-1:0]; host_data = hd[EW-1:0];
    rel_valid  = rv;  rel_acct  = ra[AW-1:0]; rel_amount = rd[EW-1:0];
    fin_accept = fa;
    cm  = dv && dp && fa;
    fwd = (cm && da == s1a) ? dn : 0;
    np  = s1v && (m_exp[s1a] + fwd + s1n <= m_lim[s1a]);
    for (int i = 0; i < NACCT; i++) begin
      v = m_exp[i];
      if (hv && ha == i && hop == 1) v = hd;
      if (hv && ha == i && hop == 2) v = 0;
      if (rv && ra == i) v = (v > rd) ? v - rd : 0;
      if (cm && da == i) begin v = v + dn; if (v > EMAX) v = EMAX; end
      m_exp[i] = v;
    end
    if (hv && hop == 0) m_lim[ha] = hd;
    e_cmtv = cm; e_cmta = da; e_cmtt = m_exp[da];
    e_chkv = s1v; e_chkp = np; e_chka = s1a;
    dv = s1v; dp = np; da = s1a; dn = s1n;
    s1v = ov; s1a = oa; s1n = longint'(oq) * longint'(op_);
    @(posedge clk);
    @(negedge clk);
    check(tag, "chk_valid (R2)", chk_valid, e_chkv);
    if (e_chkv) begin
      check(tag, "chk_pass (R3)", chk_pass, e_chkp);
      check(tag, "chk_acct (R2)", chk_acct, e_chka);
    end
    check(tag, "cmt_valid (R4)", cmt_valid, e_cmtv);
    if (e_cmtv) begin
      check(tag, "cmt_acct (R4)", cmt_acct, e_cmta);
      check(tag, "cmt_total (R4)", cmt_total, e_cmtt);
    end
  endtask

  task automatic idle(string tag);
    step(tag, 0,0,0,0, 0,0,0,0, 0,0,0, 0);
  endtask

  task automatic order(string tag, int a, int q, int p);
    step(tag, 1,a,q,p, 0,0,0,0, 0,0,0, 0);
  endtask

  task automatic host(string tag, int op, int a, longint unsigned d);
    step(tag, 0,0,0,0, 1,op,a,d, 0,0,0, 0);
  endtask

  task automatic accept(string tag, bit fa);
    step(tag, 0,0,0,0, 0,0,0,0, 0,0,0, fa);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    ord_valid = 0; ord_acct = 0; ord_qty = 0; ord_price = 0; fin_accept = 0;
    host_valid = 0; host_op = 0; host_acct = 0; host_data = 0;
    rel_valid = 0; rel_acct = 0; rel_amount = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "chk_valid in reset", chk_valid, 0);
    check("R1", "cmt_valid in reset", cmt_valid, 0);
    rst_n = 1'b1;
    repeat (4) idle("R1");

    // R1: zero ceilings after reset
    order("R1", 0, 0, 5); idle("R1"); idle("R1");
    order("R1", 1, 1, 1); idle("R1"); idle("R1");

    // R6 + R3: ceiling written with the order, exact equality passes, then charge
    step("R6", 1,2,10,100, 1,0,2,1000, 0,0,0, 0); idle("R6"); accept("R4", 1); idle("R4");
    order("R3", 2, 1, 1); idle("R3"); accept("R3", 1); idle("R3");

    // R4: unaccepted pass consumes nothing
    host("R4", 0, 3, 500);
    order("R4", 3, 5, 100); idle("R4"); accept("R4", 0); idle("R4");
    order("R4", 3, 5, 100); idle("R4"); accept("R4", 1); idle("R4");

    // R5: back-to-back same account, forwarded charge
    host("R5", 0, 4, 300);
    order("R5", 4, 10, 20); order("R5", 4, 10, 20); accept("R5", 1); accept("R5", 1); idle("R5");
    host("R5", 0, 4, 500);
    order("R5", 4, 10, 10); order("R5", 4, 10, 20); accept("R5", 0); accept("R5", 1); idle("R5");

    // R8: release floors at zero
    step("R8", 0,0,0,0, 0,0,0,0, 1,2,5000, 0);
    order("R8", 2, 10, 100); idle("R8"); accept("R8", 1); idle("R8");

    // R7: exposure write, no-op code, clear
    host("R7", 0, 5, 1000); host("R7", 1, 5, 700);
    order("R7", 5, 3, 100); idle("R7"); accept("R7", 1); idle("R7");
    order("R7", 5, 1, 1); idle("R7"); idle("R7");
    host("R7", 3, 5, 0);
    order("R7", 5, 1, 1); idle("R7"); idle("R7");
    host("R7", 2, 5, 0);
    order("R7", 5, 10, 100); idle("R7"); accept("R7", 1); idle("R7");

    // R9: host write, release and charge in one cycle
    host("R9", 0, 6, 100000);
    order("R9", 6, 10, 10); idle("R9");
    step("R9", 0,0,0,0, 1,1,6,50, 1,6,20, 1); idle("R9");

    // R10: charge on top of a full exposure stays at the maximum
    order("R10", 6, 1, 1); idle("R10");
    step("R10", 0,0,0,0, 1,1,6,EMAX, 0,0,0, 1); idle("R10");
    host("R10", 2, 6, 0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit ov, hv, rv, fa;
      int oa, oq, op_, hop, ha, ra;
      longint unsigned hd, rd;
      ov  = ($urandom % 3) != 0;
      oa  = (($urandom % 8) == 0) ? int'($urandom % NACCT) : int'($urandom % 4);
      oq  = $urandom % 64;
      op_ = $urandom % 64;
      hv  = ($urandom % 10) == 0;
      hop = $urandom % 4;
      ha  = $urandom % 4;
      hd  = (hop == 0) ? longint'($urandom % 20000) : longint'($urandom % 8000);
      rv  = ($urandom % 12) == 0;
      ra  = $urandom % 4;
      rd  = $urandom % 3000;
      fa  = ($urandom % 4) != 0;
      step("RND", ov,oa,oq,op_, hv,hop,ha,hd, rv,ra,rd, fa);
    end
    repeat (3) idle("RND");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule